// File: doc/BRIEF.md
# Nonvolatile Memory Protection Access Controller

This block is a policy gate placed in front of a small nonvolatile memory subsystem. Every access request names who is asking (the on-chip processor or an external programmer), what it wants to do (read, write, row erase or bulk erase) and a byte address. The gate sorts the address into one of three regions: an eight-entry identification area, a block of configuration registers, or the data EEPROM. It then weighs the request against four static protection inputs and answers with a grant flag and a reason code.

The decision is combinational. The grant, the reason code and a response-valid flag are registered, so they appear one clock after the request strobe. A granted bulk erase also raises a one-cycle pulse that tells the storage side to clear its protection bits along with the memory contents. The gate does not hold the memory array, time the programming pulses or run the programmer's serial link.

Top module: `nvm_access_guard`

## Requirements
- R1: An address outside the identification area (0x200000 to 0x200007), the configuration area (0x300000 to 0x30000F) and the data area (0xF00000 to 0xF000FF) is denied with reason code 4, whatever the operation. This code takes priority over every other reason.
- R2: While lockDataAccess is 1, an external read of the data area is denied with code 1, and an external write to it is denied with code 2.
- R3: While lockDataWrite is 1, a write to the data area is denied with code 2 for both requesters.
- R4: A read of the data area by the processor (reqExt = 0) is always granted with code 0, whatever the lock inputs are.
- R5: While lockCfgWrite is 1, a write to the configuration area is denied with code 2. Reads of the configuration area are always granted.
- R6: The first configuration location (offset 0) holds the configuration lock word. A processor write to it is denied with code 5 even when no lock is set, and this code outranks code 2. An external write to it follows R5.
- R7: Reads and writes of the identification area are granted with code 0 for both requesters, whatever the lock inputs are, including lockCode.
- R8: A row erase (reqOp = 2) of a protected region is denied with code 3, and is granted otherwise. The data area counts as protected when lockDataAccess or lockDataWrite is 1, the configuration area when lockCfgWrite is 1, and the identification area when lockCode is 1.
- R9: A bulk erase (reqOp = 3) at a valid address from the external programmer is granted whatever the locks are, and clearProtect is 1 for exactly the cycle its response is valid. A bulk erase from the processor is denied with code 5 and clearProtect stays 0.
- R10: respValid is 1 exactly one clock after a cycle with reqValid = 1. In a cycle after reqValid = 0, respValid, respGrant and clearProtect are 0 and respStatus is 0.
- R11: While rstN is 0, respValid, respGrant and clearProtect are 0 and respStatus is 0. Operation codes are read 0, write 1, row erase 2 and bulk erase 3. Every response that is granted carries code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqExt | input | 1 | 1 = external programmer, 0 = on-chip processor |
| reqOp | input | 2 | 0 read, 1 write, 2 row erase, 3 bulk erase |
| reqAddr | input | ADDR_W (24) | Byte address of the access |
| lockDataAccess | input | 1 | Blocks external reads and writes of the data area |
| lockDataWrite | input | 1 | Blocks all writes to the data area |
| lockCfgWrite | input | 1 | Blocks writes to the configuration area |
| lockCode | input | 1 | Code protection; blocks row erase of the identification area |
| respValid | output | 1 | Response valid, one clock after the strobe |
| respGrant | output | 1 | 1 = access allowed |
| respStatus | output | 3 | 0 ok, 1 read locked, 2 write locked, 3 erase locked, 4 bad address, 5 not permitted |
| clearProtect | output | 1 | One-cycle pulse that clears the protection bits after a granted bulk erase |

## Verification
Every cycle, the assertions check the one-cycle response timing, the rule that a grant always carries code 0, and that clearProtect only pulses on a granted external bulk erase. They also check that the data-area locks always deny the accesses they cover, that processor data reads are never refused, and that processor writes to the lock word always get code 5. The order of priority among the reason codes, the region boundaries at 0x200007/0x200008 and the exact code for each denial are shown only by the bench's directed scenarios. So are the facts that the identification area ignores every lock and that clearProtect drops again after one cycle.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

  typedef enum logic [1:0] {
    OP_READ       = 2'd0,
    OP_WRITE      = 2'd1,
    OP_ROW_ERASE  = 2'd2,
    OP_BULK_ERASE = 2'd3
  } nvmOp_e;

  typedef enum logic [2:0] {
    ST_OK            = 3'd0,
    ST_READ_LOCKED   = 3'd1,
    ST_WRITE_LOCKED  = 3'd2,
    ST_ERASE_LOCKED  = 3'd3,
    ST_BAD_ADDR      = 3'd4,
    ST_NOT_PERMITTED = 3'd5
  } nvmStatus_e;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_ID   = 2'd1,
    RG_CFG  = 2'd2,
    RG_DATA = 2'd3
  } nvmRegion_e;

  localparam int NUM_REGIONS = 3;

  // strobes handed from the policy logic to the response registers
  typedef struct packed {
    logic       grant;
    logic       clear;
    nvmStatus_e status;
  } ctrlStrobe_t;

endpackage

// File: rtl/nvm_range_match.sv
module nvm_range_match #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int SIZE = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  localparam logic [ADDR_W:0] SIZE_W = (ADDR_W+1)'(SIZE);

  // a wrapped subtraction avoids overflow of base plus size at the top of the map
  always_comb begin
    offset = addr - BASE;
    hit    = ({1'b0, offset} < SIZE_W);
  end
endmodule

// File: rtl/nvm_region_decode.sv
module nvm_region_decode
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] ID_BASE   = 24'h200000,
  parameter int                ID_SIZE   = 8,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 24'h300000,
  parameter int                CFG_SIZE  = 16,
  parameter logic [ADDR_W-1:0] DATA_BASE = 24'hF00000,
  parameter int                DATA_SIZE = 256,
  parameter int                LOCK_WORD_OFFSET = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output nvmRegion_e        region,
  output logic              lockWordHit
);
  logic [NUM_REGIONS-1:0] hits;
  logic [ADDR_W-1:0]      offsets [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    localparam logic [ADDR_W-1:0] RBASE = (g == 0) ? ID_BASE  : (g == 1) ? CFG_BASE  : DATA_BASE;
    localparam int                RSIZE = (g == 0) ? ID_SIZE  : (g == 1) ? CFG_SIZE  : DATA_SIZE;
    nvm_range_match #(.ADDR_W(ADDR_W), .BASE(RBASE), .SIZE(RSIZE)) u_match (
      .addr  (addr),
      .hit   (hits[g]),
      .offset(offsets[g])
    );
  end

  always_comb begin
    region = RG_NONE;
    if (hits[0])      region = RG_ID;
    else if (hits[1]) region = RG_CFG;
    else if (hits[2]) region = RG_DATA;
    lockWordHit = hits[1] && !hits[0] && (offsets[1] == ADDR_W'(LOCK_WORD_OFFSET));
  end
endmodule

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl
  import nvm_guard_pkg::*;
(
  input  logic        reqExt,
  input  nvmOp_e      reqOp,
  input  nvmRegion_e  region,
  input  logic        lockWordHit,
  input  logic        lockDataAccess,
  input  logic        lockDataWrite,
  input  logic        lockCfgWrite,
  input  logic        lockCode,
  output ctrlStrobe_t strobe
);
  nvmStatus_e verdict;
  logic       regionProtected;

  always_comb begin
    unique case (region)
      RG_DATA: regionProtected = lockDataAccess | lockDataWrite;
      RG_CFG:  regionProtected = lockCfgWrite;
      RG_ID:   regionProtected = lockCode;
      default: regionProtected = 1'b0;
    endcase
  end

  always_comb begin
    verdict = ST_OK;
    if (region == RG_NONE) begin
      verdict = ST_BAD_ADDR;
    end else begin
      unique case (reqOp)
        OP_READ: begin
          if (region == RG_DATA && reqExt && lockDataAccess) verdict = ST_READ_LOCKED;
        end
        OP_WRITE: begin
          if (region == RG_DATA) begin
            if (lockDataWrite || (reqExt && lockDataAccess)) verdict = ST_WRITE_LOCKED;
          end else if (region == RG_CFG) begin
            if (!reqExt && lockWordHit) verdict = ST_NOT_PERMITTED;
            else if (lockCfgWrite)      verdict = ST_WRITE_LOCKED;
          end
        end
        OP_ROW_ERASE: begin
          if (regionProtected) verdict = ST_ERASE_LOCKED;
        end
        OP_BULK_ERASE: begin
          if (!reqExt) verdict = ST_NOT_PERMITTED;
        end
        default: verdict = ST_BAD_ADDR;
      endcase
    end
  end

  always_comb begin
    strobe.status = verdict;
    strobe.grant  = (verdict == ST_OK);
    strobe.clear  = (verdict == ST_OK) && (reqOp == OP_BULK_ERASE);
  end
endmodule

// File: rtl/nvm_guard_dp.sv
module nvm_guard_dp
  import nvm_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  ctrlStrobe_t strobe,
  output logic        respValid,
  output logic        respGrant,
  output nvmStatus_e  respStatus,
  output logic        clearProtect
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid    <= 1'b0;
      respGrant    <= 1'b0;
      respStatus   <= ST_OK;
      clearProtect <= 1'b0;
    end else if (reqValid) begin
      respValid    <= 1'b1;
      respGrant    <= strobe.grant;
      respStatus   <= strobe.status;
      clearProtect <= strobe.clear;
    end else begin
      respValid    <= 1'b0;
      respGrant    <= 1'b0;
      respStatus   <= ST_OK;
      clearProtect <= 1'b0;
    end
  end
endmodule

// File: rtl/nvm_access_guard.sv
module nvm_access_guard
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] ID_BASE   = 24'h200000,
  parameter int                ID_SIZE   = 8,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 24'h300000,
  parameter int                CFG_SIZE  = 16,
  parameter logic [ADDR_W-1:0] DATA_BASE = 24'hF00000,
  parameter int                DATA_SIZE = 256,
  parameter int                LOCK_WORD_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqExt,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              lockDataAccess,
  input  logic              lockDataWrite,
  input  logic              lockCfgWrite,
  input  logic              lockCode,
  output logic              respValid,
  output logic              respGrant,
  output logic [2:0]        respStatus,
  output logic              clearProtect
);
  nvmRegion_e  region;
  logic        lockWordHit;
  ctrlStrobe_t strobe;
  nvmStatus_e  statusQ;

  nvm_region_decode #(
    .ADDR_W(ADDR_W), .ID_BASE(ID_BASE), .ID_SIZE(ID_SIZE),
    .CFG_BASE(CFG_BASE), .CFG_SIZE(CFG_SIZE),
    .DATA_BASE(DATA_BASE), .DATA_SIZE(DATA_SIZE),
    .LOCK_WORD_OFFSET(LOCK_WORD_OFFSET)
  ) u_decode (
    .addr       (reqAddr),
    .region     (region),
    .lockWordHit(lockWordHit)
  );

  nvm_guard_ctrl u_ctrl (
    .reqExt        (reqExt),
    .reqOp         (nvmOp_e'(reqOp)),
    .region        (region),
    .lockWordHit   (lockWordHit),
    .lockDataAccess(lockDataAccess),
    .lockDataWrite (lockDataWrite),
    .lockCfgWrite  (lockCfgWrite),
    .lockCode      (lockCode),
    .strobe        (strobe)
  );

  nvm_guard_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .strobe      (strobe),
    .respValid   (respValid),
    .respGrant   (respGrant),
    .respStatus  (statusQ),
    .clearProtect(clearProtect)
  );

  assign respStatus = statusQ;
endmodule

// File: rtl/nvm_guard_checker.sv
module nvm_guard_checker #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 24'h300000,
  parameter logic [ADDR_W-1:0] DATA_BASE = 24'hF00000,
  parameter int                DATA_SIZE = 256,
  parameter int                LOCK_WORD_OFFSET = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqExt,
  input logic [1:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              lockDataAccess,
  input logic              lockDataWrite,
  input logic              respValid,
  input logic              respGrant,
  input logic [2:0]        respStatus,
  input logic              clearProtect
);
  localparam logic [ADDR_W:0]   DATA_SIZE_W = (ADDR_W+1)'(DATA_SIZE);
  localparam logic [ADDR_W-1:0] LOCK_ADDR   = CFG_BASE + ADDR_W'(LOCK_WORD_OFFSET);

  logic [ADDR_W-1:0] dataOff;
  logic              inData;
  always_comb begin
    dataOff = reqAddr - DATA_BASE;
    inData  = ({1'b0, dataOff} < DATA_SIZE_W);
  end

  // R10: a response follows each strobe by exactly one cycle
  a_r10_resp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!respValid && !respGrant && !clearProtect && respStatus == 3'd0));

  // R11: a grant never carries a nonzero reason
  a_r11_grant_ok_code: assert property (@(posedge clk) disable iff (!rstN)
    respGrant |-> (respValid && respStatus == 3'd0));

  // R4: processor data reads are never refused
  a_r4_cpu_data_read: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqExt && reqOp == 2'd0 && inData) |=> respGrant);

  // R2: external data access under the access lock is denied
  a_r2_ext_data_locked: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqExt && lockDataAccess && inData && reqOp[1] == 1'b0) |=> !respGrant);

  // R3: data writes under the write lock are denied
  a_r3_data_write_locked: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lockDataWrite && inData && reqOp == 2'd1) |=> (!respGrant && respStatus == 3'd2));

  // R6: processor writes to the lock word
  a_r6_lock_word_cpu: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqExt && reqOp == 2'd1 && reqAddr == LOCK_ADDR) |=> (respStatus == 3'd5));

  // R9: the clear pulse only answers an external bulk erase
  a_r9_clear_source: assert property (@(posedge clk) disable iff (!rstN)
    clearProtect |-> (respGrant && $past(reqValid) && $past(reqExt) && $past(reqOp) == 2'd3));

  // R1: a bad address is never granted
  a_r1_bad_addr_denied: assert property (@(posedge clk) disable iff (!rstN)
    (respStatus == 3'd4) |-> !respGrant);
endmodule

bind nvm_access_guard nvm_guard_checker #(
  .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .DATA_BASE(DATA_BASE),
  .DATA_SIZE(DATA_SIZE), .LOCK_WORD_OFFSET(LOCK_WORD_OFFSET)
) u_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqExt(reqExt), .reqOp(reqOp),
  .reqAddr(reqAddr), .lockDataAccess(lockDataAccess), .lockDataWrite(lockDataWrite),
  .respValid(respValid), .respGrant(respGrant), .respStatus(respStatus),
  .clearProtect(clearProtect)
);

// File: tb/nvm_access_guard_test.sv
module nvm_access_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, RE = 2'd2, BE = 2'd3;
  localparam logic [2:0] OK = 3'd0, RLK = 3'd1, WLK = 3'd2, ELK = 3'd3, BAD = 3'd4, NP = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqExt = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [23:0] reqAddr = '0;
  logic        lockDataAccess = 1'b0, lockDataWrite = 1'b0, lockCfgWrite = 1'b0, lockCode = 1'b0;
  logic        respValid, respGrant, clearProtect;
  logic [2:0]  respStatus;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  nvm_access_guard uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqExt(reqExt), .reqOp(reqOp),
    .reqAddr(reqAddr), .lockDataAccess(lockDataAccess), .lockDataWrite(lockDataWrite),
    .lockCfgWrite(lockCfgWrite), .lockCode(lockCode), .respValid(respValid),
    .respGrant(respGrant), .respStatus(respStatus), .clearProtect(clearProtect)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkVal(string tag, logic [7:0] act, logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setLocks(logic da, logic dw, logic cw, logic cc);
    @(negedge clk);
    lockDataAccess = da; lockDataWrite = dw; lockCfgWrite = cw; lockCode = cc;
  endtask

  // drive one request, then sample its registered response one clock later
  task automatic issue(string tag, logic ext, logic [1:0] op, logic [23:0] addr,
                       logic expGrant, logic [2:0] expStatus, logic expClear);
    @(negedge clk);
    reqValid = 1'b1; reqExt = ext; reqOp = op; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    checkVal({tag, " valid"}, {7'd0, respValid}, 8'd1);
    checkVal({tag, " grant"}, {7'd0, respGrant}, {7'd0, expGrant});
    checkVal({tag, " status"}, {5'd0, respStatus}, {5'd0, expStatus});
    checkVal({tag, " clear"}, {7'd0, clearProtect}, {7'd0, expClear});
  endtask

  task automatic checkIdle(string tag);
    @(negedge clk);
    checkVal({tag, " idle valid"}, {7'd0, respValid}, 8'd0);
    checkVal({tag, " idle grant"}, {7'd0, respGrant}, 8'd0);
    checkVal({tag, " idle status"}, {5'd0, respStatus}, 8'd0);
    checkVal({tag, " idle clear"}, {7'd0, clearProtect}, 8'd0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkVal("R11 reset valid", {7'd0, respValid}, 8'd0);
    checkVal("R11 reset grant", {7'd0, respGrant}, 8'd0);
    checkVal("R11 reset status", {5'd0, respStatus}, 8'd0);
    checkVal("R11 reset clear", {7'd0, clearProtect}, 8'd0);
    rstN = 1'b1;
  endtask

  task automatic testBadAddress();
    setLocks(0, 0, 0, 0);
    issue("R1 low addr", 1'b0, RD, 24'h000000, 1'b0, BAD, 1'b0);
    issue("R1 past id end", 1'b1, WR, 24'h200008, 1'b0, BAD, 1'b0);
    issue("R1 past cfg end", 1'b0, RD, 24'h300010, 1'b0, BAD, 1'b0);
    issue("R1 bulk at bad", 1'b1, BE, 24'hF00100, 1'b0, BAD, 1'b0);
    checkIdle("R10 after bad");
  endtask

  task automatic testDataLocks();
    setLocks(1, 0, 0, 0);
    issue("R2 ext read locked", 1'b1, RD, 24'hF00010, 1'b0, RLK, 1'b0);
    issue("R2 ext write locked", 1'b1, WR, 24'hF000FF, 1'b0, WLK, 1'b0);
    issue("R4 cpu read under access lock", 1'b0, RD, 24'hF00010, 1'b1, OK, 1'b0);
    issue("R2 cpu write unaffected", 1'b0, WR, 24'hF00000, 1'b1, OK, 1'b0);
    setLocks(0, 1, 0, 0);
    issue("R3 cpu write locked", 1'b0, WR, 24'hF00020, 1'b0, WLK, 1'b0);
    issue("R3 ext write locked", 1'b1, WR, 24'hF00020, 1'b0, WLK, 1'b0);
    issue("R3 ext read allowed", 1'b1, RD, 24'hF00020, 1'b1, OK, 1'b0);
    setLocks(1, 1, 1, 1);
    issue("R4 cpu read all locks", 1'b0, RD, 24'hF000FF, 1'b1, OK, 1'b0);
    setLocks(0, 0, 0, 0);
    issue("R2 ext read unlocked", 1'b1, RD, 24'hF00001, 1'b1, OK, 1'b0);
  endtask

  task automatic testConfig();
    setLocks(0, 0, 1, 0);
    issue("R5 cpu cfg write locked", 1'b0, WR, 24'h300004, 1'b0, WLK, 1'b0);
    issue("R5 ext cfg read locked", 1'b1, RD, 24'h300004, 1'b1, OK, 1'b0);
    issue("R6 ext lock word under lock", 1'b1, WR, 24'h300000, 1'b0, WLK, 1'b0);
    issue("R6 cpu lock word under lock", 1'b0, WR, 24'h300000, 1'b0, NP, 1'b0);
    setLocks(0, 0, 0, 0);
    issue("R5 cpu cfg write open", 1'b0, WR, 24'h30000F, 1'b1, OK, 1'b0);
    issue("R6 cpu lock word open", 1'b0, WR, 24'h300000, 1'b0, NP, 1'b0);
    issue("R6 ext lock word open", 1'b1, WR, 24'h300000, 1'b1, OK, 1'b0);
  endtask

  task automatic testIdArea();
    setLocks(1, 1, 1, 1);
    issue("R7 id read code locked", 1'b1, RD, 24'h200000, 1'b1, OK, 1'b0);
    issue("R7 id cpu write all locks", 1'b0, WR, 24'h200007, 1'b1, OK, 1'b0);
    issue("R7 id ext write all locks", 1'b1, WR, 24'h200003, 1'b1, OK, 1'b0);
  endtask

  task automatic testRowErase();
    setLocks(1, 0, 0, 1);
    issue("R8 row erase data locked", 1'b1, RE, 24'hF00040, 1'b0, ELK, 1'b0);
    issue("R8 row erase id code locked", 1'b0, RE, 24'h200002, 1'b0, ELK, 1'b0);
    issue("R8 row erase cfg open", 1'b0, RE, 24'h300008, 1'b1, OK, 1'b0);
    setLocks(0, 0, 1, 0);
    issue("R8 row erase cfg locked", 1'b1, RE, 24'h300008, 1'b0, ELK, 1'b0);
    issue("R8 row erase data open", 1'b1, RE, 24'hF00040, 1'b1, OK, 1'b0);
    issue("R8 row erase id open", 1'b1, RE, 24'h200002, 1'b1, OK, 1'b0);
  endtask

  task automatic testBulkErase();
    setLocks(1, 1, 1, 1);
    issue("R9 ext bulk all locks", 1'b1, BE, 24'hF00000, 1'b1, OK, 1'b1);
    checkIdle("R9 clear drops after one cycle");
    issue("R9 cpu bulk denied", 1'b0, BE, 24'hF00000, 1'b0, NP, 1'b0);
    issue("R9 ext bulk id area", 1'b1, BE, 24'h200000, 1'b1, OK, 1'b1);
    checkIdle("R10 after bulk");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    testReset();
    testBadAddress();
    testDataLocks();
    testConfig();
    testIdArea();
    testRowErase();
    testBulkErase();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule